// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node directory of a small distributed shared-memory system. For every memory line that lives at this home it keeps a 2-bit directory state (uncached, shared, dirty) and a presence vector with one bit per remote node. Remote nodes and the home's own local bus send it reads, read-for-ownership (RFO) requests, writebacks and acknowledgements. It answers with data, ownership grants, invalidations, forwards to the dirty owner, recalls, writeback acknowledgements or negative acknowledgements (NAK).

A line with a multi-step transaction in flight is marked busy. It stays busy while invalidation acks are counted down, while a forwarded read waits for the owner's copy of the data, while a recall waits for the owner's writeback, or while an ownership transfer waits for the new owner's transfer ack. Any read or RFO that hits a busy line is refused with a NAK and must be retried. Line data is held in a small internal array that reset fills with the line index.

Requests enter on a valid/ready port, one per cycle. Responses leave through a single registered valid/ready port. Invalidations for one RFO go out back to back in ascending node order, and no new request is taken while they are being sent.

Top module: `hd_home_dir`

## Requirements
- R1: After reset every line is uncached with an empty presence vector and not busy, line data equals the line index, resp_valid is 0 and req_ready is 1.
- R2: Request kinds are READ=0, RFO=1, WB=2, INV_ACK=3, XFER_ACK=4. Response kinds are DATA=0, OWN=1, INV=2, FWD_READ=3, FWD_RFO=4, RECALL=5, NAK=6, WB_ACK=7. A remote READ to an uncached or shared line returns DATA with the line data to the requester, sets its presence bit and leaves the line shared.
- R3: A remote READ to a dirty line sends FWD_READ to the owner, carrying the requester in resp_req, and makes the line busy. The owner's WB stores the data, clears busy and leaves the line shared with owner and requester marked, with no response.
- R4: A remote RFO to an uncached line, or to a shared line whose only marked node is the requester, returns OWN with data at once and leaves the line dirty with only the requester marked.
- R5: A remote RFO to a shared line with other marked nodes sends INV to each of them in ascending node order. It returns OWN with data to the requester only after one INV_ACK per INV, whether or not the node still held the line.
- R6: A remote RFO to a dirty line owned by another node sends FWD_RFO to the owner with the requester in resp_req. The line stays busy until XFER_ACK arrives from that requester, after which it is dirty with only the requester marked.
- R7: Local requests (req_local=1) get responses with resp_local=1. A local READ to a clean line returns DATA and changes nothing, and a local RFO to an uncached line returns OWN. A local RFO to a shared line invalidates every marked node before granting. A local READ or RFO to a dirty line sends RECALL to the owner and grants DATA or OWN with the written-back data. All of these leave the line uncached.
- R8: A remote WB from the dirty owner to an idle line stores the data, makes the line uncached and returns WB_ACK. A local WB to an idle uncached line stores the data and returns WB_ACK. A local WB to any other line gets a NAK.
- R9: A READ or RFO to a busy line, a READ or RFO from the node that already owns the dirty line, and a WB to a busy line from a node other than the awaited owner all get a NAK to the sender and leave directory and data unchanged.
- R10: A dirty line always has exactly one presence bit set, a shared line at least one, and an uncached line none.
- R11: A response is held stable while resp_ready is low. req_ready is low while the output register is full and not draining, and while invalidations are being sent.
- R12: INV_ACK or XFER_ACK to a line not waiting for it, and a remote WB from a node that does not own an idle line, change no state. The first two give no response and the last gives only WB_ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_kind | input | 3 | Request kind code |
| req_local | input | 1 | Request comes from the home's local bus |
| req_src | input | NID_W (2) | Sending remote node |
| req_line | input | LINE_W (4) | Directory line index |
| req_data | input | DATA_W (32) | Writeback data |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken this cycle when valid |
| resp_kind | output | 3 | Response kind code |
| resp_local | output | 1 | Response is for the local bus |
| resp_dst | output | NID_W (2) | Destination remote node |
| resp_req | output | NID_W (2) | Original requester, for forwards and invalidations |
| resp_line | output | LINE_W (4) | Directory line index |
| resp_data | output | DATA_W (32) | Line data for DATA and OWN |

## Verification
The bench targets racing traffic on a single line. A read or RFO during collection of invalidation acks or during an ownership transfer must be NAKed. A design that skipped the busy check would grant a second owner, and the follow-up forward would go to the wrong node. Chained transfers check that the presence vector is replaced, not merged. Otherwise the next RFO would fan out invalidations instead of a single forward. A writeback from a non-owner must be dropped, and silent drops still need their acks: a design that updated memory, or granted before the last ack, would return the wrong data or grant too early. Invalidation order and recall data are checked under output backpressure.

// File: rtl/hd_pkg.sv
package hd_pkg;

    typedef enum logic [1:0] {
        ST_UNC = 2'd0,
        ST_SHR = 2'd1,
        ST_DRT = 2'd2
    } dir_st_e;

    typedef enum logic [2:0] {
        RQ_READ = 3'd0,
        RQ_RFO  = 3'd1,
        RQ_WB   = 3'd2,
        RQ_IACK = 3'd3,
        RQ_XACK = 3'd4
    } req_e;

    typedef enum logic [2:0] {
        RS_DATA   = 3'd0,
        RS_OWN    = 3'd1,
        RS_INV    = 3'd2,
        RS_FRD    = 3'd3,
        RS_FRFO   = 3'd4,
        RS_RECALL = 3'd5,
        RS_NAK    = 3'd6,
        RS_WBACK  = 3'd7
    } rsp_e;

    typedef enum logic [1:0] {
        PD_INV    = 2'd0,
        PD_FRD    = 2'd1,
        PD_FRFO   = 2'd2,
        PD_RECALL = 2'd3
    } pend_e;

    localparam int unsigned HD_VEC_MAX = 32;

    function automatic int unsigned bit_count(input logic [HD_VEC_MAX-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < HD_VEC_MAX; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int unsigned first_set(input logic [HD_VEC_MAX-1:0] v);
        int unsigned idx;
        idx = 0;
        for (int i = HD_VEC_MAX - 1; i >= 0; i--) if (v[i]) idx = i;
        return idx;
    endfunction

endpackage

// File: rtl/hd_dir_table.sv
module hd_dir_table #(
    parameter int unsigned LINES  = 16,
    parameter int unsigned ENT_W  = 12,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] addr,
    input  logic              ent_we,
    input  logic [ENT_W-1:0]  ent_d,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_d,
    output logic [ENT_W-1:0]  ent_q,
    output logic [DATA_W-1:0] dat_q
);

    logic [ENT_W-1:0]  dir_arr [LINES];
    logic [DATA_W-1:0] dat_arr [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(LINES); i++) begin
                dir_arr[i] <= '0;
                dat_arr[i] <= DATA_W'(i);
            end
        end else begin
            if (ent_we) dir_arr[addr] <= ent_d;
            if (dat_we) dat_arr[addr] <= dat_d;
        end
    end

    assign ent_q = dir_arr[addr];
    assign dat_q = dat_arr[addr];

endmodule

// File: rtl/hd_policy.sv
module hd_policy
    import hd_pkg::*;
#(
    parameter int unsigned NODES  = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ENT_W  = 12,
    localparam int unsigned NID_W = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int unsigned CNT_W = $clog2(NODES + 1)
) (
    input  req_e              kind,
    input  logic              loc,
    input  logic [NID_W-1:0]  src,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ENT_W-1:0]  ent_q,
    input  logic [DATA_W-1:0] dat_q,
    output logic              ent_we,
    output logic [ENT_W-1:0]  ent_d,
    output logic              dat_we,
    output logic [DATA_W-1:0] dat_d,
    output logic              msg_v,
    output rsp_e              msg_kind,
    output logic              msg_loc,
    output logic [NID_W-1:0]  msg_dst,
    output logic [NID_W-1:0]  msg_rq,
    output logic [DATA_W-1:0] msg_data,
    output logic [NODES-1:0]  inv_mask,
    output logic [NID_W-1:0]  inv_rq,
    output logic [1:0]        wr_st,
    output logic [NODES-1:0]  wr_pv,
    output logic              cur_busy
);

    typedef struct packed {
        dir_st_e          st;
        logic [NODES-1:0] pv;
        logic             busy;
        pend_e            pend;
        logic [CNT_W-1:0] cnt;
        logic [NID_W-1:0] preq;
        logic             plocal;
        logic             prfo;
    } ent_t;

    ent_t             e, n;
    logic [NODES-1:0] src_oh, others;
    logic [NID_W-1:0] owner;
    logic             is_owner;

    assign e        = ent_t'(ent_q);
    assign src_oh   = NODES'(1) << src;
    assign others   = e.pv & ~src_oh;
    assign owner    = NID_W'(first_set(HD_VEC_MAX'(e.pv)));
    assign is_owner = (e.st == ST_DRT) && e.pv[src];
    assign cur_busy = e.busy;

    always_comb begin
        n        = e;
        ent_we   = 1'b0;
        dat_we   = 1'b0;
        dat_d    = wdata;
        msg_v    = 1'b0;
        msg_kind = RS_NAK;
        msg_loc  = loc;
        msg_dst  = loc ? '0 : src;
        msg_rq   = src;
        msg_data = dat_q;
        inv_mask = '0;
        inv_rq   = loc ? '0 : src;

        unique case (kind)
            RQ_READ, RQ_RFO: begin
                msg_v = 1'b1;
                if (e.busy) begin
                    msg_kind = RS_NAK;
                end else if (loc) begin
                    if (e.st == ST_DRT) begin
                        msg_kind = RS_RECALL;
                        msg_loc  = 1'b0;
                        msg_dst  = owner;
                        msg_rq   = '0;
                        ent_we   = 1'b1;
                        n.busy   = 1'b1;
                        n.pend   = PD_RECALL;
                        n.plocal = 1'b1;
                        n.prfo   = (kind == RQ_RFO);
                    end else if (kind == RQ_READ || e.st == ST_UNC) begin
                        msg_kind = (kind == RQ_READ) ? RS_DATA : RS_OWN;
                    end else begin
                        msg_v    = 1'b0;
                        inv_mask = e.pv;
                        ent_we   = 1'b1;
                        n.busy   = 1'b1;
                        n.pend   = PD_INV;
                        n.cnt    = CNT_W'(bit_count(HD_VEC_MAX'(e.pv)));
                        n.plocal = 1'b1;
                        n.prfo   = 1'b1;
                    end
                end else if (is_owner) begin
                    msg_kind = RS_NAK;
                end else if (e.st == ST_DRT) begin
                    msg_kind = (kind == RQ_READ) ? RS_FRD : RS_FRFO;
                    msg_dst  = owner;
                    ent_we   = 1'b1;
                    n.busy   = 1'b1;
                    n.pend   = (kind == RQ_READ) ? PD_FRD : PD_FRFO;
                    n.preq   = src;
                    n.plocal = 1'b0;
                end else if (kind == RQ_READ) begin
                    msg_kind = RS_DATA;
                    ent_we   = 1'b1;
                    n.st     = ST_SHR;
                    n.pv     = e.pv | src_oh;
                end else if (others == '0) begin
                    msg_kind = RS_OWN;
                    ent_we   = 1'b1;
                    n.st     = ST_DRT;
                    n.pv     = src_oh;
                end else begin
                    msg_v    = 1'b0;
                    inv_mask = others;
                    ent_we   = 1'b1;
                    n.busy   = 1'b1;
                    n.pend   = PD_INV;
                    n.cnt    = CNT_W'(bit_count(HD_VEC_MAX'(others)));
                    n.preq   = src;
                    n.plocal = 1'b0;
                    n.prfo   = 1'b1;
                end
            end
            RQ_WB: begin
                msg_v = 1'b1;
                if (loc) begin
                    if (!e.busy && e.st == ST_UNC) begin
                        msg_kind = RS_WBACK;
                        dat_we   = 1'b1;
                    end else begin
                        msg_kind = RS_NAK;
                    end
                end else if (e.busy) begin
                    if ((e.pend == PD_FRD || e.pend == PD_RECALL) && e.pv[src]) begin
                        dat_we = 1'b1;
                        ent_we = 1'b1;
                        n.busy = 1'b0;
                        if (e.pend == PD_FRD) begin
                            msg_v = 1'b0;
                            n.st  = ST_SHR;
                            n.pv  = e.pv | (NODES'(1) << e.preq);
                        end else begin
                            msg_kind = e.prfo ? RS_OWN : RS_DATA;
                            msg_loc  = 1'b1;
                            msg_dst  = '0;
                            msg_rq   = '0;
                            msg_data = wdata;
                            n.st     = ST_UNC;
                            n.pv     = '0;
                        end
                    end else begin
                        msg_kind = RS_NAK;
                    end
                end else if (is_owner) begin
                    msg_kind = RS_WBACK;
                    dat_we   = 1'b1;
                    ent_we   = 1'b1;
                    n.st     = ST_UNC;
                    n.pv     = '0;
                end else begin
                    msg_kind = RS_WBACK;
                end
            end
            RQ_IACK: begin
                if (!loc && e.busy && e.pend == PD_INV) begin
                    ent_we = 1'b1;
                    if (e.cnt > CNT_W'(1)) begin
                        n.cnt = e.cnt - CNT_W'(1);
                    end else begin
                        n.cnt    = '0;
                        n.busy   = 1'b0;
                        msg_v    = 1'b1;
                        msg_kind = e.prfo ? RS_OWN : RS_DATA;
                        msg_loc  = e.plocal;
                        msg_dst  = e.plocal ? '0 : e.preq;
                        msg_rq   = e.preq;
                        if (e.plocal) begin
                            n.st = ST_UNC;
                            n.pv = '0;
                        end else begin
                            n.st = ST_DRT;
                            n.pv = NODES'(1) << e.preq;
                        end
                    end
                end
            end
            RQ_XACK: begin
                if (!loc && e.busy && e.pend == PD_FRFO && src == e.preq) begin
                    ent_we = 1'b1;
                    n.busy = 1'b0;
                    n.st   = ST_DRT;
                    n.pv   = src_oh;
                end
            end
            default: ;
        endcase
    end

    assign ent_d = ENT_W'(n);
    assign wr_st = n.st;
    assign wr_pv = n.pv;

endmodule

// File: rtl/hd_home_dir.sv
module hd_home_dir
    import hd_pkg::*;
#(
    parameter int unsigned NODES  = 4,
    parameter int unsigned LINES  = 16,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned NID_W  = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int unsigned LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int unsigned CNT_W  = $clog2(NODES + 1),
    localparam int unsigned ENT_W  = 2 + NODES + 1 + 2 + CNT_W + NID_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic              req_local,
    input  logic [NID_W-1:0]  req_src,
    input  logic [LINE_W-1:0] req_line,
    input  logic [DATA_W-1:0] req_data,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [2:0]        resp_kind,
    output logic              resp_local,
    output logic [NID_W-1:0]  resp_dst,
    output logic [NID_W-1:0]  resp_req,
    output logic [LINE_W-1:0] resp_line,
    output logic [DATA_W-1:0] resp_data
);

    typedef enum logic {S_IDLE, S_INV} seq_e;

    seq_e              seq_q;
    logic              out_free, fire;
    logic [ENT_W-1:0]  ent_q, ent_d;
    logic [DATA_W-1:0] dat_q, dat_d;
    logic              tbl_we, dat_we;
    logic              msg_v, msg_loc;
    rsp_e              msg_kind, out_kind;
    logic [NID_W-1:0]  msg_dst, msg_rq, inv_rq, inv_rq_q;
    logic [DATA_W-1:0] msg_data;
    logic [NODES-1:0]  inv_mask, inv_mask_q, inv_left;
    logic [LINE_W-1:0] inv_line_q;
    logic [NID_W-1:0]  inv_dst;
    logic [1:0]        wr_st;
    logic [NODES-1:0]  wr_pv;
    logic              rd_busy, in_inv;

    assign out_free  = !resp_valid || resp_ready;
    assign in_inv    = (seq_q == S_INV);
    assign req_ready = !in_inv && out_free;
    assign fire      = req_valid && req_ready;

    hd_dir_table #(
        .LINES (LINES),
        .ENT_W (ENT_W),
        .DATA_W(DATA_W)
    ) u_table (
        .clk   (clk),
        .rst   (rst),
        .addr  (req_line),
        .ent_we(fire && tbl_we),
        .ent_d (ent_d),
        .dat_we(fire && dat_we),
        .dat_d (dat_d),
        .ent_q (ent_q),
        .dat_q (dat_q)
    );

    hd_policy #(
        .NODES (NODES),
        .DATA_W(DATA_W),
        .ENT_W (ENT_W)
    ) u_policy (
        .kind    (req_e'(req_kind)),
        .loc     (req_local),
        .src     (req_src),
        .wdata   (req_data),
        .ent_q   (ent_q),
        .dat_q   (dat_q),
        .ent_we  (tbl_we),
        .ent_d   (ent_d),
        .dat_we  (dat_we),
        .dat_d   (dat_d),
        .msg_v   (msg_v),
        .msg_kind(msg_kind),
        .msg_loc (msg_loc),
        .msg_dst (msg_dst),
        .msg_rq  (msg_rq),
        .msg_data(msg_data),
        .inv_mask(inv_mask),
        .inv_rq  (inv_rq),
        .wr_st   (wr_st),
        .wr_pv   (wr_pv),
        .cur_busy(rd_busy)
    );

    assign inv_dst  = NID_W'(first_set(HD_VEC_MAX'(inv_mask_q)));
    assign inv_left = inv_mask_q & ~(NODES'(1) << inv_dst);

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q      <= S_IDLE;
            inv_mask_q <= '0;
            inv_line_q <= '0;
            inv_rq_q   <= '0;
        end else if (in_inv) begin
            if (out_free) begin
                inv_mask_q <= inv_left;
                if (inv_left == '0) seq_q <= S_IDLE;
            end
        end else if (fire && inv_mask != '0) begin
            seq_q      <= S_INV;
            inv_mask_q <= inv_mask;
            inv_line_q <= req_line;
            inv_rq_q   <= inv_rq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            out_kind   <= RS_NAK;
            resp_local <= 1'b0;
            resp_dst   <= '0;
            resp_req   <= '0;
            resp_line  <= '0;
            resp_data  <= '0;
        end else if (out_free) begin
            if (in_inv) begin
                resp_valid <= 1'b1;
                out_kind   <= RS_INV;
                resp_local <= 1'b0;
                resp_dst   <= inv_dst;
                resp_req   <= inv_rq_q;
                resp_line  <= inv_line_q;
                resp_data  <= '0;
            end else if (fire && msg_v) begin
                resp_valid <= 1'b1;
                out_kind   <= msg_kind;
                resp_local <= msg_loc;
                resp_dst   <= msg_dst;
                resp_req   <= msg_rq;
                resp_line  <= req_line;
                resp_data  <= msg_data;
            end else begin
                resp_valid <= 1'b0;
            end
        end
    end

    assign resp_kind = out_kind;

endmodule

// File: rtl/hd_home_dir_chk.sv
module hd_home_dir_chk #(
    parameter int unsigned NODES  = 4,
    parameter int unsigned LINES  = 16,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned NID_W  = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int unsigned LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_kind,
    input logic              resp_valid,
    input logic              resp_ready,
    input logic [2:0]        resp_kind,
    input logic              resp_local,
    input logic [NID_W-1:0]  resp_dst,
    input logic [NID_W-1:0]  resp_req,
    input logic [LINE_W-1:0] resp_line,
    input logic [DATA_W-1:0] resp_data,
    input logic              tbl_we,
    input logic [1:0]        wr_st,
    input logic [NODES-1:0]  wr_pv,
    input logic              rd_busy,
    input logic              in_inv
);

    logic hit_busy;
    assign hit_busy = req_valid && req_ready && rd_busy && (req_kind == 3'd0 || req_kind == 3'd1);

    a_r10_dirty_single: assert property (@(posedge clk) disable iff (rst)
        (tbl_we && wr_st == 2'd2) |-> $countones(wr_pv) == 1);

    a_r10_shared_nonempty: assert property (@(posedge clk) disable iff (rst)
        (tbl_we && wr_st == 2'd1) |-> wr_pv != '0);

    a_r10_uncached_empty: assert property (@(posedge clk) disable iff (rst)
        (tbl_we && wr_st == 2'd0) |-> wr_pv == '0);

    a_r11_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=> resp_valid &&
        $stable({resp_kind, resp_local, resp_dst, resp_req, resp_line, resp_data}));

    a_r11_no_take_during_inv: assert property (@(posedge clk) disable iff (rst)
        in_inv |-> !req_ready);

    a_r9_busy_gets_nak: assert property (@(posedge clk) disable iff (rst)
        hit_busy |=> resp_valid && resp_kind == 3'd6);

    a_r9_nak_keeps_entry: assert property (@(posedge clk) disable iff (rst)
        hit_busy |-> !tbl_we);

endmodule

bind hd_home_dir hd_home_dir_chk #(
    .NODES (NODES),
    .LINES (LINES),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .resp_valid(resp_valid),
    .resp_ready(resp_ready),
    .resp_kind (resp_kind),
    .resp_local(resp_local),
    .resp_dst  (resp_dst),
    .resp_req  (resp_req),
    .resp_line (resp_line),
    .resp_data (resp_data),
    .tbl_we    (tbl_we),
    .wr_st     (wr_st),
    .wr_pv     (wr_pv),
    .rd_busy   (rd_busy),
    .in_inv    (in_inv)
);

// File: tb/hd_home_dir_test.sv
module hd_home_dir_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NODES = 4;
    localparam int LINES = 16;
    localparam int DW    = 32;

    localparam int Q_READ = 0, Q_RFO = 1, Q_WB = 2, Q_IACK = 3, Q_XACK = 4;
    localparam int P_DATA = 0, P_OWN = 1, P_INV = 2, P_FRD = 3, P_FRFO = 4,
                   P_RECALL = 5, P_NAK = 6, P_WBACK = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_kind = '0;
    logic          req_local = 1'b0;
    logic [1:0]    req_src = '0;
    logic [3:0]    req_line = '0;
    logic [DW-1:0] req_data = '0;
    logic          resp_valid;
    logic          resp_ready = 1'b1;
    logic [2:0]    resp_kind;
    logic          resp_local;
    logic [1:0]    resp_dst;
    logic [1:0]    resp_req;
    logic [3:0]    resp_line;
    logic [DW-1:0] resp_data;

    always #2.5 clk = ~clk;

    hd_home_dir #(.NODES(NODES), .LINES(LINES), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_local(req_local), .req_src(req_src), .req_line(req_line), .req_data(req_data),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_kind(resp_kind),
        .resp_local(resp_local), .resp_dst(resp_dst), .resp_req(resp_req),
        .resp_line(resp_line), .resp_data(resp_data)
    );

    typedef struct {
        int          kind;
        bit          loc;
        int          dst;
        int          rq;
        int          line;
        logic [DW-1:0] data;
        bit          crq;
        bit          cdat;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_run = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    bp    = 1'b0;

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    endtask

    task automatic expect_msg(input int kind, input bit loc, input int dst, input int rq,
                              input int line, input logic [DW-1:0] data,
                              input bit crq, input bit cdat, input string tag);
        exp_t x;
        x.kind = kind; x.loc = loc; x.dst = dst; x.rq = rq; x.line = line;
        x.data = data; x.crq = crq; x.cdat = cdat;
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    task automatic send(input int kind, input bit loc, input int src, input int line,
                        input logic [DW-1:0] data);
        @(negedge clk);
        #0.5;
        while (!req_ready) begin
            @(negedge clk);
            #0.5;
        end
        req_valid = 1'b1;
        req_kind  = 3'(kind);
        req_local = loc;
        req_src   = 2'(src);
        req_line  = 4'(line);
        req_data  = data;
        @(posedge clk);
        #0.5;
        req_valid = 1'b0;
    endtask

    task automatic settle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    // monitor: drives resp_ready and checks each response taken
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog: run hung, got cycle %0d expected completion", cyc);
            finish_run();
        end
        resp_ready = bp ? (cyc % 3 != 0) : 1'b1;
        if (!rst && resp_valid && resp_ready) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R12: unexpected response kind=%0d dst=%0d line=%0d, expected none",
                         resp_kind, resp_dst, resp_line);
            end else begin
                exp_t  x;
                string t;
                bit    ok;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                ok = (int'(resp_kind) == x.kind) && (resp_local == x.loc) &&
                     (int'(resp_line) == x.line) &&
                     (x.loc || int'(resp_dst) == x.dst) &&
                     (!x.crq || int'(resp_req) == x.rq) &&
                     (!x.cdat || resp_data == x.data);
                if (!ok) begin
                    n_bad++;
                    $display("FAIL %s: got kind=%0d loc=%0d dst=%0d req=%0d line=%0d data=%0h, expected kind=%0d loc=%0d dst=%0d req=%0d line=%0d data=%0h",
                             t, resp_kind, resp_local, resp_dst, resp_req, resp_line, resp_data,
                             x.kind, x.loc, x.dst, x.rq, x.line, x.data);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #0.5;
        n_run++;
        if (resp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: resp_valid got %0b expected 0", resp_valid);
        end
        n_run++;
        if (req_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R1: req_ready got %0b expected 1", req_ready);
        end

        // R1, R7: local read of clean line returns reset data
        expect_msg(P_DATA, 1, 0, 0, 5, 32'd5, 0, 1, "R1 R7 local read reset data");
        send(Q_READ, 1, 0, 5, 0);
        settle();

        // R2: two remote readers
        expect_msg(P_DATA, 0, 1, 0, 2, 32'd2, 0, 1, "R2 read uncached");
        send(Q_READ, 0, 1, 2, 0);
        expect_msg(P_DATA, 0, 2, 0, 2, 32'd2, 0, 1, "R2 read shared");
        send(Q_READ, 0, 2, 2, 0);
        settle();

        // R5: RFO invalidates sharers, NAK while collecting acks (R9)
        expect_msg(P_INV, 0, 1, 3, 2, 0, 1, 0, "R5 inv node1");
        expect_msg(P_INV, 0, 2, 3, 2, 0, 1, 0, "R5 inv node2");
        send(Q_RFO, 0, 3, 2, 0);
        expect_msg(P_NAK, 0, 0, 0, 2, 0, 0, 0, "R9 read during inv collection");
        send(Q_READ, 0, 0, 2, 0);
        send(Q_IACK, 0, 1, 2, 0);
        settle();
        expect_msg(P_OWN, 0, 3, 0, 2, 32'd2, 0, 1, "R5 own after last ack");
        send(Q_IACK, 0, 2, 2, 0);
        settle();

        // R3: read to dirty is forwarded, owner writes back
        expect_msg(P_FRD, 0, 3, 0, 2, 0, 1, 0, "R3 forward read to owner");
        send(Q_READ, 0, 0, 2, 0);
        send(Q_WB, 0, 3, 2, 32'hAB);
        settle();
        expect_msg(P_INV, 0, 0, 1, 2, 0, 1, 0, "R3 shared marks requester");
        expect_msg(P_INV, 0, 3, 1, 2, 0, 1, 0, "R3 shared marks owner");
        send(Q_RFO, 0, 1, 2, 0);
        send(Q_IACK, 0, 0, 2, 0);
        expect_msg(P_OWN, 0, 1, 0, 2, 32'hAB, 0, 1, "R3 written back data");
        send(Q_IACK, 0, 3, 2, 0);
        settle();

        // R6: ownership transfer, NAKs while waiting for XFER_ACK
        expect_msg(P_FRFO, 0, 1, 2, 2, 0, 1, 0, "R6 forward rfo to owner");
        send(Q_RFO, 0, 2, 2, 0);
        expect_msg(P_NAK, 0, 0, 0, 2, 0, 0, 0, "R9 read during transfer");
        send(Q_READ, 0, 0, 2, 0);
        expect_msg(P_NAK, 0, 3, 0, 2, 0, 0, 0, "R9 wb from non-owner while busy");
        send(Q_WB, 0, 3, 2, 32'hDEAD);
        send(Q_XACK, 0, 2, 2, 0);
        settle();
        expect_msg(P_FRFO, 0, 2, 0, 2, 0, 1, 0, "R6 R10 single new owner after transfer");
        send(Q_RFO, 0, 0, 2, 0);
        send(Q_XACK, 0, 0, 2, 0);
        settle();

        // R8: owner writeback, R4: immediate ownership
        expect_msg(P_WBACK, 0, 0, 0, 2, 0, 0, 0, "R8 owner writeback");
        send(Q_WB, 0, 0, 2, 32'h55);
        expect_msg(P_DATA, 0, 1, 0, 2, 32'h55, 0, 1, "R8 data after writeback");
        send(Q_READ, 0, 1, 2, 0);
        expect_msg(P_OWN, 0, 1, 0, 2, 32'h55, 0, 1, "R4 rfo by sole sharer");
        send(Q_RFO, 0, 1, 2, 0);
        expect_msg(P_OWN, 0, 2, 0, 7, 32'd7, 0, 1, "R4 rfo uncached");
        send(Q_RFO, 0, 2, 7, 0);
        settle();

        // R7: local RFO recalls dirty line
        expect_msg(P_RECALL, 0, 2, 0, 7, 0, 0, 0, "R7 recall owner");
        send(Q_RFO, 1, 0, 7, 0);
        expect_msg(P_OWN, 1, 0, 0, 7, 32'h77, 0, 1, "R7 local grant recalled data");
        send(Q_WB, 0, 2, 7, 32'h77);
        expect_msg(P_DATA, 0, 1, 0, 7, 32'h77, 0, 1, "R7 line uncached after recall");
        send(Q_READ, 0, 1, 7, 0);
        settle();

        // R7: local RFO on shared line, R8 local writeback
        expect_msg(P_INV, 0, 1, 0, 7, 0, 0, 0, "R7 local rfo invalidates");
        send(Q_RFO, 1, 0, 7, 0);
        expect_msg(P_OWN, 1, 0, 0, 7, 32'h77, 0, 1, "R7 local own after ack");
        send(Q_IACK, 0, 1, 7, 0);
        expect_msg(P_WBACK, 1, 0, 0, 7, 0, 0, 0, "R8 local writeback");
        send(Q_WB, 1, 0, 7, 32'h99);
        expect_msg(P_DATA, 0, 3, 0, 7, 32'h99, 0, 1, "R8 local data stored");
        send(Q_READ, 0, 3, 7, 0);
        settle();

        // R12: stray acks and stale writeback
        send(Q_IACK, 0, 1, 9, 0);
        send(Q_XACK, 0, 1, 9, 0);
        settle();
        expect_msg(P_DATA, 0, 0, 0, 9, 32'd9, 0, 1, "R12 stray acks no effect");
        send(Q_READ, 0, 0, 9, 0);
        expect_msg(P_WBACK, 0, 1, 0, 9, 0, 0, 0, "R12 stale writeback acked");
        send(Q_WB, 0, 1, 9, 32'h1234);
        expect_msg(P_DATA, 0, 2, 0, 9, 32'd9, 0, 1, "R12 stale writeback data dropped");
        send(Q_READ, 0, 2, 9, 0);
        expect_msg(P_INV, 0, 0, 3, 9, 0, 1, 0, "R12 R5 presence kept node0");
        expect_msg(P_INV, 0, 2, 3, 9, 0, 1, 0, "R12 R5 presence kept node2");
        send(Q_RFO, 0, 3, 9, 0);
        send(Q_IACK, 0, 0, 9, 0);
        expect_msg(P_OWN, 0, 3, 0, 9, 32'd9, 0, 1, "R5 own line9");
        send(Q_IACK, 0, 2, 9, 0);
        settle();

        // R9: requests by the current owner
        expect_msg(P_OWN, 0, 2, 0, 11, 32'd11, 0, 1, "R4 rfo line11");
        send(Q_RFO, 0, 2, 11, 0);
        expect_msg(P_NAK, 0, 2, 0, 11, 0, 0, 0, "R9 rfo by owner");
        send(Q_RFO, 0, 2, 11, 0);
        expect_msg(P_NAK, 0, 2, 0, 11, 0, 0, 0, "R9 read by owner");
        send(Q_READ, 0, 2, 11, 0);
        expect_msg(P_FRD, 0, 2, 1, 11, 0, 1, 0, "R9 owner kept after nak");
        send(Q_READ, 0, 1, 11, 0);
        send(Q_WB, 0, 2, 11, 32'hB0);
        settle();

        // R11: same flows under output backpressure
        bp = 1'b1;
        expect_msg(P_DATA, 0, 0, 0, 12, 32'd12, 0, 1, "R11 read n0");
        send(Q_READ, 0, 0, 12, 0);
        expect_msg(P_DATA, 0, 1, 0, 12, 32'd12, 0, 1, "R11 read n1");
        send(Q_READ, 0, 1, 12, 0);
        expect_msg(P_DATA, 0, 2, 0, 12, 32'd12, 0, 1, "R11 read n2");
        send(Q_READ, 0, 2, 12, 0);
        expect_msg(P_INV, 0, 0, 3, 12, 0, 1, 0, "R11 R5 inv order 0");
        expect_msg(P_INV, 0, 1, 3, 12, 0, 1, 0, "R11 R5 inv order 1");
        expect_msg(P_INV, 0, 2, 3, 12, 0, 1, 0, "R11 R5 inv order 2");
        send(Q_RFO, 0, 3, 12, 0);
        send(Q_IACK, 0, 2, 12, 0);
        send(Q_IACK, 0, 0, 12, 0);
        expect_msg(P_OWN, 0, 3, 0, 12, 32'd12, 0, 1, "R11 own after three acks");
        send(Q_IACK, 0, 1, 12, 0);
        expect_msg(P_RECALL, 0, 3, 0, 12, 0, 0, 0, "R11 R7 local read recall");
        send(Q_READ, 1, 0, 12, 0);
        expect_msg(P_NAK, 1, 0, 0, 12, 0, 0, 0, "R9 local rfo on busy line");
        send(Q_RFO, 1, 0, 12, 0);
        expect_msg(P_DATA, 1, 0, 0, 12, 32'hC3, 0, 1, "R7 local read gets recalled data");
        send(Q_WB, 0, 3, 12, 32'hC3);
        expect_msg(P_NAK, 1, 0, 0, 2, 0, 0, 0, "R8 local wb to remote dirty line");
        send(Q_WB, 1, 0, 2, 32'hEE);
        settle();
        bp = 1'b0;

        expect_msg(P_FRD, 0, 1, 3, 2, 0, 1, 0, "R8 R9 line2 still owned by node1");
        send(Q_READ, 0, 3, 2, 0);
        expect_msg(P_DATA, 0, 0, 0, 2, 32'hF0, 0, 1, "R3 data from owner writeback");
        send(Q_WB, 0, 1, 2, 32'hF0);
        send(Q_READ, 0, 0, 2, 0);
        settle();

        n_run++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R11: pending responses got %0d expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule